// File: doc/BRIEF.md
# Hashed Memory Conflict Buffer

This block watches for memory conflicts between loads that a compiler has hoisted above possibly aliasing stores and the stores that later execute. Each hoisted load (a preload) records its address in a small set-associative buffer and names the destination register it wrote. Each later store looks up the same buffer. When a store matches a recorded address, the conflict bit of the register named in that entry is raised. A check operation names a register. It reports whether that register's conflict bit is set, which tells the pipeline whether to branch to correction code, and it consumes the bit.

The buffer line is chosen by an exclusive-OR fold of the address bits above the low three bits. Tracking is therefore done at 8-byte granularity, and strided address streams spread across lines. Conflicts are reported conservatively. A store that only shares the 8-byte word of a preload counts as a conflict. A preload that pushes an older entry out of a full line also flags the register of the entry it displaced.

All four command ports carry a valid qualifier and are accepted every cycle. There is no back-pressure, so no ready signals exist. Within one cycle the effects are ordered as follows: store first, then check, then preload, and the clear input last.

Top module: `mcb_conflict_buffer`

## Requirements
- R1: After reset every buffer entry is invalid and every conflict bit is zero, so a check of any register reports not-taken.
- R2: The line index is the XOR of 4-bit groups of address bits taken upward from bit 3. Group g covers bits [3+4g+3 : 3+4g], and missing bits above the address width count as zero. Address bits [2:0] take part in neither the index nor the tag, so a store that differs from a preload only in those bits matches it.
- R3: A preload writes {valid, address bits above bit 2, register number} into the lowest-numbered free way of its line. A store with the same line and tag sets the conflict bit of the recorded register.
- R4: A store whose tag differs from every valid entry in its line sets no conflict bit.
- R5: A preload into a line whose two ways are both valid evicts the way named by that line's replacement pointer, and sets the evicted register's conflict bit. The pointer starts at way 0 and advances after each eviction.
- R6: A check returns the register's conflict bit and clears it. In the same cycle it invalidates every entry tagged with that register, so later stores to those addresses flag nothing.
- R7: A preload to a register clears that register's conflict bit.
- R8: A store and a check in the same cycle are ordered store first. A check of the register the store hits reports taken.
- R9: Asserting the clear input invalidates all entries and zeroes all conflict bits at the end of that cycle.
- R10: The check response valid goes high exactly one cycle after a check is issued, and the taken output is low whenever the response valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Invalidate all entries and conflict bits |
| pl_valid_i | input | 1 | Preload command valid |
| pl_addr_i | input | ADDR_W | Preload byte address |
| pl_rd_i | input | REG_W | Preload destination register |
| st_valid_i | input | 1 | Store command valid |
| st_addr_i | input | ADDR_W | Store byte address |
| chk_valid_i | input | 1 | Check command valid |
| chk_rd_i | input | REG_W | Register named by the check |
| chk_resp_valid_o | output | 1 | Check response valid |
| chk_taken_o | output | 1 | Branch to correction code |

## Verification
The check response is registered and appears one clock edge after the cycle in which the check is presented. Preload, store and clear effects are visible to a check issued in the following cycle, and a store's effect is also visible to a check issued in the same cycle. The bench drives each command one nanosecond after a rising edge and holds it for exactly one cycle. It samples the response one nanosecond after the next rising edge, so every comparison lands on the first cycle in which the result is due. Expected outcomes come from addresses built arithmetically so that their line index is known, and from the ordering rules in the requirements.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  // Byte offset bits ignored for both index and tag (8-byte granularity).
  localparam int unsigned GRAN_BITS = 3;

  function automatic int unsigned ceil_div(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction
endpackage

// File: rtl/mcb_hash.sv
module mcb_hash
  import mcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned TAG_W = ADDR_W - GRAN_BITS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int unsigned NGRP = ceil_div(TAG_W, IDX_W);

  logic [TAG_W-1:0] word;
  logic [IDX_W-1:0] grp [NGRP];

  assign word  = addr_i[ADDR_W-1:GRAN_BITS];
  assign tag_o = word;

  // Slice the word into index-wide groups; bits past the top read as zero.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar b = 0; b < IDX_W; b++) begin : g_bit
      if (g * IDX_W + b < TAG_W) begin : g_in
        assign grp[g][b] = word[g*IDX_W+b];
      end else begin : g_pad
        assign grp[g][b] = 1'b0;
      end
    end
  end

  always_comb begin
    idx_o = '0;
    for (int g = 0; g < NGRP; g++) idx_o = idx_o ^ grp[g];
  end
endmodule

// File: rtl/mcb_line_array.sv
module mcb_line_array #(
  parameter int unsigned LINES = 16,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 29,
  parameter int unsigned REG_W = 5,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  // store lookup
  input  logic                        st_valid_i,
  input  logic [IDX_W-1:0]            st_idx_i,
  input  logic [TAG_W-1:0]            st_tag_i,
  output logic [WAYS-1:0]             st_hit_o,
  output logic [WAYS-1:0][REG_W-1:0]  st_rd_o,
  // check invalidation
  input  logic                        chk_valid_i,
  input  logic [REG_W-1:0]            chk_rd_i,
  // preload insertion
  input  logic                        pl_valid_i,
  input  logic [IDX_W-1:0]            pl_idx_i,
  input  logic [TAG_W-1:0]            pl_tag_i,
  input  logic [REG_W-1:0]            pl_rd_i,
  output logic                        evict_valid_o,
  output logic [REG_W-1:0]            evict_rd_o
);
  logic [WAYS-1:0]             vld_q   [LINES];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [LINES];
  logic [WAYS-1:0][REG_W-1:0]  rd_q    [LINES];
  logic [WAY_W-1:0]            ptr_q   [LINES];
  logic [WAYS-1:0]             vld_chk [LINES];

  logic [WAYS-1:0]  line_v;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] victim;
  logic             line_full;

  // Store lookup sees the entries as they stood before this cycle's check.
  for (genvar w = 0; w < WAYS; w++) begin : g_st
    assign st_hit_o[w] = st_valid_i && vld_q[st_idx_i][w]
                         && (tag_q[st_idx_i][w] == st_tag_i);
    assign st_rd_o[w]  = rd_q[st_idx_i][w];
  end

  // A check drops every entry tagged with its register.
  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign vld_chk[l][w] = vld_q[l][w]
                             && !(chk_valid_i && (rd_q[l][w] == chk_rd_i));
    end
  end

  assign line_v    = vld_chk[pl_idx_i];
  assign line_full = &line_v;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!line_v[w]) free_way = WAY_W'(w);
    end
  end

  assign victim        = line_full ? ptr_q[pl_idx_i] : free_way;
  assign evict_valid_o = pl_valid_i && line_full;
  assign evict_rd_o    = rd_q[pl_idx_i][victim];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        vld_q[l] <= '0;
        tag_q[l] <= '0;
        rd_q[l]  <= '0;
        ptr_q[l] <= '0;
      end
    end else if (clr_i) begin
      for (int l = 0; l < LINES; l++) begin
        vld_q[l] <= '0;
        ptr_q[l] <= '0;
      end
    end else begin
      for (int l = 0; l < LINES; l++) vld_q[l] <= vld_chk[l];
      if (pl_valid_i) begin
        vld_q[pl_idx_i][victim] <= 1'b1;
        tag_q[pl_idx_i][victim] <= pl_tag_i;
        rd_q[pl_idx_i][victim]  <= pl_rd_i;
        if (line_full) begin
          ptr_q[pl_idx_i] <= (ptr_q[pl_idx_i] == WAY_W'(WAYS - 1))
                             ? '0 : ptr_q[pl_idx_i] + 1'b1;
        end
      end
    end
  end

  logic any_vld;
  always_comb begin
    any_vld = 1'b0;
    for (int l = 0; l < LINES; l++) any_vld = any_vld | (|vld_q[l]);
  end

  // R3: the inserted entry is present and carries the preload's register.
  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid_i && !clr_i) |=>
      (vld_q[$past(pl_idx_i)][$past(victim)]
       && rd_q[$past(pl_idx_i)][$past(victim)] == $past(pl_rd_i)))
    else $error("p_fill_r3");

  // R9: clear leaves no valid entry behind.
  p_clr_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !any_vld)
    else $error("p_clr_empty_r9");
endmodule

// File: rtl/mcb_conflict_bits.sv
module mcb_conflict_bits #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [NREG-1:0]  st_set_i,
  input  logic             chk_valid_i,
  input  logic [REG_W-1:0] chk_rd_i,
  input  logic             pl_valid_i,
  input  logic [REG_W-1:0] pl_rd_i,
  input  logic             evict_valid_i,
  input  logic [REG_W-1:0] evict_rd_i,
  output logic             chk_hit_o,
  output logic [NREG-1:0]  bits_o
);
  logic [NREG-1:0] bits_q;
  logic [NREG-1:0] after_st;
  logic [NREG-1:0] bits_d;

  // Order within a cycle: store sets, check reads and clears,
  // preload clears its own register, eviction sets the victim.
  assign after_st  = bits_q | st_set_i;
  assign chk_hit_o = after_st[chk_rd_i];

  always_comb begin
    bits_d = after_st;
    if (chk_valid_i)   bits_d[chk_rd_i]   = 1'b0;
    if (pl_valid_i)    bits_d[pl_rd_i]    = 1'b0;
    if (evict_valid_i) bits_d[evict_rd_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bits_q <= '0;
    else if (clr_i) bits_q <= '0;
    else            bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  // R9: clear zeroes every conflict bit.
  p_clr_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (bits_q == '0))
    else $error("p_clr_bits_r9");

  // R5: an eviction always leaves its victim flagged.
  p_evict_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid_i && !clr_i) |=> bits_q[$past(evict_rd_i)])
    else $error("p_evict_flag_r5");
endmodule

// File: rtl/mcb_conflict_buffer.sv
module mcb_conflict_buffer
  import mcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINES  = 16,
  parameter int unsigned WAYS   = 2,
  parameter int unsigned NREG   = 32,
  localparam int unsigned REG_W = $clog2(NREG),
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned TAG_W = ADDR_W - GRAN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              pl_valid_i,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [REG_W-1:0]  pl_rd_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              chk_valid_i,
  input  logic [REG_W-1:0]  chk_rd_i,
  output logic              chk_resp_valid_o,
  output logic              chk_taken_o
);
  logic [IDX_W-1:0] pl_idx, st_idx;
  logic [TAG_W-1:0] pl_tag, st_tag;
  logic [WAYS-1:0]             st_hit;
  logic [WAYS-1:0][REG_W-1:0]  st_rd;
  logic             evict_valid;
  logic [REG_W-1:0] evict_rd;
  logic [NREG-1:0]  st_set;
  logic [NREG-1:0]  conf_bits;
  logic             chk_hit;

  mcb_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pl_hash (
    .addr_i(pl_addr_i), .idx_o(pl_idx), .tag_o(pl_tag)
  );

  mcb_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_st_hash (
    .addr_i(st_addr_i), .idx_o(st_idx), .tag_o(st_tag)
  );

  mcb_line_array #(
    .LINES(LINES), .WAYS(WAYS), .TAG_W(TAG_W), .REG_W(REG_W)
  ) u_lines (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .st_valid_i   (st_valid_i),
    .st_idx_i     (st_idx),
    .st_tag_i     (st_tag),
    .st_hit_o     (st_hit),
    .st_rd_o      (st_rd),
    .chk_valid_i  (chk_valid_i),
    .chk_rd_i     (chk_rd_i),
    .pl_valid_i   (pl_valid_i),
    .pl_idx_i     (pl_idx),
    .pl_tag_i     (pl_tag),
    .pl_rd_i      (pl_rd_i),
    .evict_valid_o(evict_valid),
    .evict_rd_o   (evict_rd)
  );

  // Turn per-way store hits into a register-indexed set mask.
  always_comb begin
    st_set = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (st_hit[w]) st_set[st_rd[w]] = 1'b1;
    end
  end

  mcb_conflict_bits #(.NREG(NREG), .REG_W(REG_W)) u_bits (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_i),
    .st_set_i     (st_set),
    .chk_valid_i  (chk_valid_i),
    .chk_rd_i     (chk_rd_i),
    .pl_valid_i   (pl_valid_i),
    .pl_rd_i      (pl_rd_i),
    .evict_valid_i(evict_valid),
    .evict_rd_i   (evict_rd),
    .chk_hit_o    (chk_hit),
    .bits_o       (conf_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_resp_valid_o <= 1'b0;
      chk_taken_o      <= 1'b0;
    end else begin
      chk_resp_valid_o <= chk_valid_i;
      chk_taken_o      <= chk_valid_i && chk_hit;
    end
  end

  p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> chk_resp_valid_o)
    else $error("p_resp_follows_r10");

  p_no_stray_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> !chk_resp_valid_o)
    else $error("p_no_stray_resp_r10");

  p_taken_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_resp_valid_o |-> !chk_taken_o)
    else $error("p_taken_qualified_r10");

  // R6: after a check its register is no longer flagged.
  p_chk_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> !conf_bits[$past(chk_rd_i)])
    else $error("p_chk_clears_r6");

  // R8: a same-cycle store hit on the checked register is reported.
  p_store_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && st_set[chk_rd_i]) |=> chk_taken_o)
    else $error("p_store_first_r8");
endmodule

// File: tb/tb_mcb_conflict_buffer.sv
`timescale 1ns/1ps
module tb_mcb_conflict_buffer;
  localparam int ADDR_W = 32;
  localparam int REG_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr_i = 1'b0;
  logic              pl_valid_i = 1'b0;
  logic [ADDR_W-1:0] pl_addr_i = '0;
  logic [REG_W-1:0]  pl_rd_i = '0;
  logic              st_valid_i = 1'b0;
  logic [ADDR_W-1:0] st_addr_i = '0;
  logic              chk_valid_i = 1'b0;
  logic [REG_W-1:0]  chk_rd_i = '0;
  logic              chk_resp_valid_o;
  logic              chk_taken_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  mcb_conflict_buffer dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .pl_valid_i(pl_valid_i), .pl_addr_i(pl_addr_i), .pl_rd_i(pl_rd_i),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i),
    .chk_valid_i(chk_valid_i), .chk_rd_i(chk_rd_i),
    .chk_resp_valid_o(chk_resp_valid_o), .chk_taken_o(chk_taken_o)
  );

  // Address on line L: group 0 holds L, groups 1 and 2 both hold X and cancel.
  function automatic logic [ADDR_W-1:0] mk(input int l, input int x);
    return ADDR_W'((l << 3) | (x << 7) | (x << 11));
  endfunction

  task automatic expect_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    pl_valid_i = 1'b0; st_valid_i = 1'b0; chk_valid_i = 1'b0; clr_i = 1'b0;
  endtask

  task automatic preload(input logic [ADDR_W-1:0] a, input int rd);
    pl_valid_i = 1'b1; pl_addr_i = a; pl_rd_i = REG_W'(rd);
    tick();
  endtask

  task automatic store(input logic [ADDR_W-1:0] a);
    st_valid_i = 1'b1; st_addr_i = a;
    tick();
  endtask

  task automatic check(input string req, input int rd, input int exp);
    chk_valid_i = 1'b1; chk_rd_i = REG_W'(rd);
    tick();
    expect_eq({req, " resp_valid"}, int'(chk_resp_valid_o), 1);
    expect_eq({req, " taken"}, int'(chk_taken_o), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset, every register not-taken.
    for (int r = 0; r < 32; r++) check("R1", r, 0);

    // R10: no response without a check.
    tick();
    expect_eq("R10 idle resp_valid", int'(chk_resp_valid_o), 0);
    expect_eq("R10 idle taken", int'(chk_taken_o), 0);

    // R2/R3: every line; store differs only in bits [2:0].
    for (int l = 0; l < 16; l++) begin
      preload(mk(l, l), l);
      store(mk(l, l) | ADDR_W'(l % 8));
      check("R2_R3 line sweep", l, 1);
    end

    // R4: different tag on same line, and different line, flag nothing.
    preload(mk(2, 1), 3);
    store(mk(2, 2));
    store(mk(7, 1));
    check("R4", 3, 0);

    // R5 and R2: third address aliases line 9 through groups 5 and 6.
    preload(mk(9, 1), 10);
    preload(mk(9, 2), 11);
    preload(ADDR_W'((9 << 3) | (5 << 23) | (5 << 27)), 12);
    check("R5 first victim way0", 10, 1);
    preload(mk(9, 4), 13);
    check("R5 pointer advanced way1", 11, 1);
    check("R5 survivor", 12, 0);
    store(mk(9, 4));
    check("R3 after eviction", 13, 1);
    store(ADDR_W'((9 << 3) | (5 << 23) | (5 << 27)));
    check("R6 invalidated survivor", 12, 0);

    // R6: check consumes the bit.
    preload(mk(1, 7), 20);
    store(mk(1, 7));
    check("R6 first", 20, 1);
    check("R6 second", 20, 0);
    // R6: check invalidates the entry.
    preload(mk(3, 1), 22);
    check("R6 no conflict yet", 22, 0);
    store(mk(3, 1));
    check("R6 entry gone", 22, 0);

    // R7: re-preload of a flagged register clears its bit.
    preload(mk(4, 1), 25);
    store(mk(4, 1));
    preload(mk(4, 2), 25);
    check("R7", 25, 0);

    // R8: store and check in one cycle.
    preload(mk(5, 1), 26);
    st_valid_i = 1'b1; st_addr_i = mk(5, 1);
    chk_valid_i = 1'b1; chk_rd_i = REG_W'(26);
    tick();
    expect_eq("R8 resp_valid", int'(chk_resp_valid_o), 1);
    expect_eq("R8 taken", int'(chk_taken_o), 1);
    check("R8 consumed", 26, 0);

    // R9: clear wipes bits and entries.
    preload(mk(8, 1), 27);
    store(mk(8, 1));
    preload(mk(8, 2), 28);
    clr_i = 1'b1;
    tick();
    check("R9 bit wiped", 27, 0);
    store(mk(8, 2));
    check("R9 entry wiped", 28, 0);

    finish_run();
  end
endmodule